// File: doc/BRIEF.md
# Dual-Issue Scoreboard With Variable Latencies

This block decides, every clock, which of two in-order instruction candidates may launch in a core that has one integer path and one floating-point path. Each candidate presents a valid bit, a class bit, a three-bit operation kind, a destination tag and two source tags. The older candidate is slot A and the younger one is slot B. The block keeps one pending flag and one down-counter per architectural register. It compares the candidates against that state and against each other, and raises an issue strobe for each slot that may go.

When an issued instruction has counted down its fixed latency, the block pulses the bit of its destination register on a writeback vector and frees the register. Because latencies differ by operation kind, results issued in different cycles can land in the same cycle. The vector then carries all of them at once.

The block has no execution datapath. It only counts cycles and reports completions. A register in its final counting cycle is treated as already available, so a dependent instruction may issue in the same cycle that the writeback bit shows.

Top module: `dual_issue_sb`

## Requirements
- R1: After reset no register is pending, so `wb_o` is all zero. A candidate whose valid bit is low never issues.
- R2: An issued instruction's latency L depends on its operation code. Code 0 (integer add/subtract) and code 1 (memory reference) take 1 cycle, code 2 (FP add) takes 2, code 3 (multiply) takes 6 and code 4 (divide) takes 15. Codes 5 to 7 behave like code 0. If the instruction issues in cycle c, `wb_o[dst]` is high in cycle c+L only, for a single cycle.
- R3: A candidate does not issue while either of its source registers is pending. The exception is a register whose writeback bit is high in that same cycle; such a register counts as ready.
- R4: A candidate does not issue while its destination register is pending, except in the cycle that register's writeback bit is high.
- R5: Slot B issues only in a cycle in which slot A also issues.
- R6: The two slots issue together only when their class bits differ (0 = integer path, 1 = floating-point path). With equal classes only slot A may go.
- R7: Slot B does not issue alongside slot A if either B source, or the B destination, equals the A destination.
- R8: The divider is not pipelined. After a divide (code 4) issues in cycle c, no other divide issues in either slot before cycle c+15.
- R9: A class-1 candidate does not issue while six class-1 results are pending, none of which has its writeback bit high in that cycle.
- R10: All results that complete in the same cycle appear together in that cycle's `wb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_valid_i | input | 1 | Slot A holds an instruction |
| a_cls_i | input | 1 | Slot A class: 0 integer, 1 floating point |
| a_op_i | input | 3 | Slot A operation code |
| a_dst_i | input | 5 | Slot A destination tag |
| a_src1_i | input | 5 | Slot A first source tag |
| a_src2_i | input | 5 | Slot A second source tag |
| b_valid_i | input | 1 | Slot B holds an instruction |
| b_cls_i | input | 1 | Slot B class |
| b_op_i | input | 3 | Slot B operation code |
| b_dst_i | input | 5 | Slot B destination tag |
| b_src1_i | input | 5 | Slot B first source tag |
| b_src2_i | input | 5 | Slot B second source tag |
| issue_a_o | output | 1 | Slot A issues this cycle |
| issue_b_o | output | 1 | Slot B issues this cycle |
| wb_o | output | 32 | One bit per register, high in its completion cycle |

## Verification
The bench measures the latency of every operation kind from issue to the writeback pulse. It also checks that the pulse lasts one cycle, which catches a counter that is off by one or a pending flag that never clears.

Dependent candidates are offered in every cycle across a producer's latency. A design without same-cycle forwarding would issue one cycle late, and one that ignores the write-after-write hazard would issue early.

The pairing cases present slot B with:
- the same class as slot A,
- a source that depends on slot A,
- the same destination as slot A,
- a slot A that is blocked.

A design that breaks the rules would dual-issue in one of these cases.

The divider is probed in both slots until it frees, and the floating-point cap is filled to exactly six. Four results from different sub-pipelines are arranged to land in one cycle, which exposes a design that drops simultaneous completions or frees the floating-point slot late.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [2:0] {
        OP_ALU  = 3'd0,
        OP_MEM  = 3'd1,
        OP_FADD = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } op_e;

    localparam logic CLS_INT = 1'b0;
    localparam logic CLS_FP  = 1'b1;

endpackage

// File: rtl/sb_entry.sv
// One register's pending state: a flag, the class of the writer, and a
// down-counter that reaches 1 in the completion cycle.
module sb_entry #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_i,
    input  logic             fp_i,
    input  logic [CNT_W-1:0] lat_i,
    output logic             pend_o,
    output logic             done_o,
    output logic             fp_o
);
    typedef struct packed {
        logic             pend;
        logic             fp;
        logic [CNT_W-1:0] cnt;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (set_i) begin
            ent_d.pend = 1'b1;
            ent_d.fp   = fp_i;
            ent_d.cnt  = lat_i;
        end else if (ent_q.pend) begin
            if (ent_q.cnt <= CNT_W'(1)) begin
                ent_d.pend = 1'b0;
                ent_d.fp   = 1'b0;
                ent_d.cnt  = '0;
            end else begin
                ent_d.cnt = ent_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign pend_o = ent_q.pend;
    assign done_o = ent_q.pend && (ent_q.cnt <= CNT_W'(1));
    assign fp_o   = ent_q.fp;

endmodule

// File: rtl/sb_hazard.sv
// Combinational readiness of one candidate against the busy vector.
module sb_hazard #(
    parameter int NREG  = 32,
    parameter int TAG_W = 5
) (
    input  logic [NREG-1:0]  busy_i,
    input  logic             valid_i,
    input  logic [TAG_W-1:0] src1_i,
    input  logic [TAG_W-1:0] src2_i,
    input  logic [TAG_W-1:0] dst_i,
    output logic             ok_o
);
    logic raw_hit;
    logic waw_hit;

    always_comb begin
        raw_hit = busy_i[src1_i] || busy_i[src2_i];
        waw_hit = busy_i[dst_i];
        ok_o    = valid_i && !raw_hit && !waw_hit;
    end

endmodule

// File: rtl/sb_fp_occ.sv
// Counts live floating-point results and reports whether another may start.
module sb_fp_occ #(
    parameter int NREG     = 32,
    parameter int FP_DEPTH = 6
) (
    input  logic [NREG-1:0] live_i,
    output logic            room_o
);
    localparam int CW = $clog2(NREG + 1);

    logic [CW-1:0] occ;

    always_comb begin
        occ = '0;
        for (int i = 0; i < NREG; i++) begin
            occ = occ + CW'(live_i[i]);
        end
        room_o = (occ < CW'(FP_DEPTH));
    end

endmodule

// File: rtl/sb_div_unit.sv
// Occupancy of the single non-pipelined divider.
module sb_div_unit #(
    parameter int CNT_W = 4,
    parameter int LAT   = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (start_i) begin
            div_d.cnt = CNT_W'(LAT);
        end else if (div_q.cnt != '0) begin
            div_d.cnt = div_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // free again in the cycle its result is written back
    assign busy_o = div_q.cnt > CNT_W'(1);

endmodule

// File: rtl/dual_issue_sb.sv
module dual_issue_sb #(
    parameter int NREG     = 32,
    parameter int FP_DEPTH = 6,
    parameter int LAT_ALU  = 1,
    parameter int LAT_MEM  = 1,
    parameter int LAT_FADD = 2,
    parameter int LAT_MUL  = 6,
    parameter int LAT_DIV  = 15,
    localparam int TAG_W   = $clog2(NREG)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             a_valid_i,
    input  logic             a_cls_i,
    input  logic [2:0]       a_op_i,
    input  logic [TAG_W-1:0] a_dst_i,
    input  logic [TAG_W-1:0] a_src1_i,
    input  logic [TAG_W-1:0] a_src2_i,
    input  logic             b_valid_i,
    input  logic             b_cls_i,
    input  logic [2:0]       b_op_i,
    input  logic [TAG_W-1:0] b_dst_i,
    input  logic [TAG_W-1:0] b_src1_i,
    input  logic [TAG_W-1:0] b_src2_i,
    output logic             issue_a_o,
    output logic             issue_b_o,
    output logic [NREG-1:0]  wb_o
);
    import sb_pkg::*;

    localparam int M1      = (LAT_ALU > LAT_MEM) ? LAT_ALU : LAT_MEM;
    localparam int M2      = (M1 > LAT_FADD) ? M1 : LAT_FADD;
    localparam int M3      = (M2 > LAT_MUL) ? M2 : LAT_MUL;
    localparam int LAT_MAX = (M3 > LAT_DIV) ? M3 : LAT_DIV;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic             issue_a;
        logic             issue_b;
        logic             div_start;
        logic [CNT_W-1:0] lat_a;
        logic [CNT_W-1:0] lat_b;
        logic [NREG-1:0]  set_a;
        logic [NREG-1:0]  set_b;
    } issue_t;

    function automatic logic [CNT_W-1:0] lat_of(input logic [2:0] op);
        case (op)
            OP_MEM:  lat_of = CNT_W'(LAT_MEM);
            OP_FADD: lat_of = CNT_W'(LAT_FADD);
            OP_MUL:  lat_of = CNT_W'(LAT_MUL);
            OP_DIV:  lat_of = CNT_W'(LAT_DIV);
            default: lat_of = CNT_W'(LAT_ALU);
        endcase
    endfunction

    logic [NREG-1:0] pend;
    logic [NREG-1:0] done;
    logic [NREG-1:0] fpv;
    logic [NREG-1:0] busy;
    logic [NREG-1:0] fp_live;
    logic            ok_a;
    logic            ok_b;
    logic            fp_room;
    logic            div_busy;
    issue_t          iss_d;

    // a register in its completion cycle is already readable and writable
    assign busy    = pend & ~done;
    assign fp_live = pend & fpv & ~done;

    sb_hazard #(.NREG(NREG), .TAG_W(TAG_W)) u_haz_a (
        .busy_i  (busy),
        .valid_i (a_valid_i),
        .src1_i  (a_src1_i),
        .src2_i  (a_src2_i),
        .dst_i   (a_dst_i),
        .ok_o    (ok_a)
    );

    sb_hazard #(.NREG(NREG), .TAG_W(TAG_W)) u_haz_b (
        .busy_i  (busy),
        .valid_i (b_valid_i),
        .src1_i  (b_src1_i),
        .src2_i  (b_src2_i),
        .dst_i   (b_dst_i),
        .ok_o    (ok_b)
    );

    sb_fp_occ #(.NREG(NREG), .FP_DEPTH(FP_DEPTH)) u_fp_occ (
        .live_i (fp_live),
        .room_o (fp_room)
    );

    sb_div_unit #(.CNT_W(CNT_W), .LAT(LAT_DIV)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (iss_d.div_start),
        .busy_o  (div_busy)
    );

    always_comb begin
        logic a_div;
        logic b_div;
        logic b_dep;

        iss_d       = '0;
        a_div       = (a_op_i == OP_DIV);
        b_div       = (b_op_i == OP_DIV);
        iss_d.lat_a = lat_of(a_op_i);
        iss_d.lat_b = lat_of(b_op_i);

        iss_d.issue_a = ok_a
                     && ((a_cls_i == CLS_INT) || fp_room)
                     && !(a_div && div_busy);

        b_dep = (b_src1_i == a_dst_i) || (b_src2_i == a_dst_i)
             || (b_dst_i == a_dst_i);

        iss_d.issue_b = ok_b && iss_d.issue_a
                     && (b_cls_i != a_cls_i)
                     && !b_dep
                     && ((b_cls_i == CLS_INT) || fp_room)
                     && !(b_div && (div_busy || a_div));

        iss_d.div_start = (iss_d.issue_a && a_div) || (iss_d.issue_b && b_div);

        for (int r = 0; r < NREG; r++) begin
            iss_d.set_a[r] = iss_d.issue_a && (a_dst_i == TAG_W'(r));
            iss_d.set_b[r] = iss_d.issue_b && (b_dst_i == TAG_W'(r));
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_ent
        logic             set_r;
        logic             fp_r;
        logic [CNT_W-1:0] lat_r;

        assign set_r = iss_d.set_a[r] || iss_d.set_b[r];
        assign fp_r  = iss_d.set_a[r] ? a_cls_i : b_cls_i;
        assign lat_r = iss_d.set_a[r] ? iss_d.lat_a : iss_d.lat_b;

        sb_entry #(.CNT_W(CNT_W)) u_ent (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (set_r),
            .fp_i   (fp_r),
            .lat_i  (lat_r),
            .pend_o (pend[r]),
            .done_o (done[r]),
            .fp_o   (fpv[r])
        );
    end

    assign issue_a_o = iss_d.issue_a;
    assign issue_b_o = iss_d.issue_b;
    assign wb_o      = done;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NREG  = 32,
    parameter int TAG_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             a_valid_i,
    input logic             a_cls_i,
    input logic [2:0]       a_op_i,
    input logic [TAG_W-1:0] a_dst_i,
    input logic             b_cls_i,
    input logic [2:0]       b_op_i,
    input logic [TAG_W-1:0] b_dst_i,
    input logic [TAG_W-1:0] b_src1_i,
    input logic [TAG_W-1:0] b_src2_i,
    input logic             issue_a_o,
    input logic             issue_b_o,
    input logic [NREG-1:0]  wb_o
);
    // R1
    valid_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_a_o |-> a_valid_i);

    // R2
    single_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_a_o && a_op_i == 3'd0) |=> wb_o[$past(a_dst_i)]);

    // R5
    in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_b_o |-> issue_a_o);

    // R6
    class_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_a_o && issue_b_o) |-> (a_cls_i != b_cls_i));

    // R7
    indep_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_a_o && issue_b_o) |->
            (b_dst_i != a_dst_i && b_src1_i != a_dst_i && b_src2_i != a_dst_i));

    // R8
    div_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((issue_a_o && a_op_i == 3'd4) || (issue_b_o && b_op_i == 3'd4)) |=>
            !((issue_a_o && a_op_i == 3'd4) || (issue_b_o && b_op_i == 3'd4)));

endmodule

bind dual_issue_sb sb_checker #(.NREG(NREG), .TAG_W(TAG_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_valid_i (a_valid_i),
    .a_cls_i   (a_cls_i),
    .a_op_i    (a_op_i),
    .a_dst_i   (a_dst_i),
    .b_cls_i   (b_cls_i),
    .b_op_i    (b_op_i),
    .b_dst_i   (b_dst_i),
    .b_src1_i  (b_src1_i),
    .b_src2_i  (b_src2_i),
    .issue_a_o (issue_a_o),
    .issue_b_o (issue_b_o),
    .wb_o      (wb_o)
);

// File: tb/sim_dual_issue_sb.sv
`timescale 1ns/1ps
module sim_dual_issue_sb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0, a_cls = 1'b0;
    logic [2:0]  a_op = 3'd0;
    logic [4:0]  a_dst = 5'd0, a_s1 = 5'd0, a_s2 = 5'd0;
    logic        b_valid = 1'b0, b_cls = 1'b0;
    logic [2:0]  b_op = 3'd0;
    logic [4:0]  b_dst = 5'd0, b_s1 = 5'd0, b_s2 = 5'd0;
    logic        issue_a, issue_b;
    logic [31:0] wb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_issue_sb u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .a_valid_i(a_valid), .a_cls_i(a_cls), .a_op_i(a_op),
        .a_dst_i(a_dst), .a_src1_i(a_s1), .a_src2_i(a_s2),
        .b_valid_i(b_valid), .b_cls_i(b_cls), .b_op_i(b_op),
        .b_dst_i(b_dst), .b_src1_i(b_s1), .b_src2_i(b_s2),
        .issue_a_o(issue_a), .issue_b_o(issue_b), .wb_o(wb)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_a(input logic c, input logic [2:0] op, input logic [4:0] d,
                         input logic [4:0] s1, input logic [4:0] s2);
        a_valid = 1'b1; a_cls = c; a_op = op; a_dst = d; a_s1 = s1; a_s2 = s2;
    endtask

    task automatic put_b(input logic c, input logic [2:0] op, input logic [4:0] d,
                         input logic [4:0] s1, input logic [4:0] s2);
        b_valid = 1'b1; b_cls = c; b_op = op; b_dst = d; b_s1 = s1; b_s2 = s2;
    endtask

    task automatic idle();
        a_valid = 1'b0; b_valid = 1'b0;
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    task automatic drain();
        idle();
        repeat (20) next();
    endtask

    task automatic t_reset();
        chk("R1 wb after reset", wb, 0);
        put_b(1'b1, 3'd2, 5'd2, 5'd0, 5'd0);
        #1;
        chk("R1 invalid A no issue", issue_a, 0);
        chk("R1 B without A", issue_b, 0);
        idle();
        next();
    endtask

    task automatic t_latency(input logic c, input logic [2:0] op, input logic [4:0] d,
                             input int lat);
        int n;
        put_a(c, op, d, 5'd0, 5'd0);
        #1;
        chk("R2 lone issue", issue_a, 1);
        next();
        idle();
        n = 1;
        while (!wb[d] && n < 40) begin
            next();
            n++;
        end
        chk("R2 latency", n, lat);
        next();
        chk("R2 one-cycle pulse", wb[d], 0);
        drain();
    endtask

    task automatic t_raw();
        put_a(1'b0, 3'd3, 5'd3, 5'd0, 5'd0);
        #1; chk("R3 producer", issue_a, 1);
        next();
        for (int k = 1; k <= 5; k++) begin
            put_a(1'b0, 3'd0, 5'd7, 5'd0, 5'd3);
            #1; chk("R3 source pending", issue_a, 0);
            next();
        end
        put_a(1'b0, 3'd0, 5'd7, 5'd0, 5'd3);
        #1; chk("R3 forward in wb cycle", issue_a, 1);
        chk("R3 wb shows", wb[3], 1);
        next();
        drain();
    endtask

    task automatic t_waw();
        put_a(1'b1, 3'd2, 5'd8, 5'd0, 5'd0);
        #1; chk("R4 producer", issue_a, 1);
        next();
        put_a(1'b0, 3'd0, 5'd8, 5'd0, 5'd0);
        #1; chk("R4 dest pending", issue_a, 0);
        next();
        #1; chk("R4 dest completing", issue_a, 1);
        next();
        drain();
    endtask

    task automatic t_pair();
        put_a(1'b0, 3'd0, 5'd1, 5'd0, 5'd0);
        put_b(1'b1, 3'd2, 5'd2, 5'd0, 5'd0);
        #1;
        chk("R6 A of pair", issue_a, 1);
        chk("R6 int+fp pair", issue_b, 1);
        next(); idle();
        chk("R2 pair A wb", wb[2:1], 2'b01);
        next();
        chk("R2 pair B wb", wb[2:1], 2'b10);
        drain();

        put_a(1'b0, 3'd0, 5'd3, 5'd0, 5'd0);
        put_b(1'b0, 3'd1, 5'd4, 5'd0, 5'd0);
        #1;
        chk("R6 same class A", issue_a, 1);
        chk("R6 same class B", issue_b, 0);
        next(); drain();

        put_a(1'b0, 3'd0, 5'd5, 5'd0, 5'd0);
        put_b(1'b1, 3'd2, 5'd6, 5'd5, 5'd0);
        #1;
        chk("R7 B reads A dst", issue_b, 0);
        next(); drain();

        put_a(1'b0, 3'd0, 5'd9, 5'd0, 5'd0);
        put_b(1'b1, 3'd2, 5'd9, 5'd0, 5'd0);
        #1;
        chk("R7 B writes A dst", issue_b, 0);
        next(); drain();

        put_a(1'b0, 3'd3, 5'd11, 5'd0, 5'd0);
        next();
        put_a(1'b0, 3'd0, 5'd12, 5'd11, 5'd0);
        put_b(1'b1, 3'd2, 5'd13, 5'd0, 5'd0);
        #1;
        chk("R5 blocked A", issue_a, 0);
        chk("R5 B behind blocked A", issue_b, 0);
        next(); drain();
    endtask

    task automatic t_div();
        put_a(1'b0, 3'd4, 5'd14, 5'd0, 5'd0);
        #1; chk("R8 first divide", issue_a, 1);
        next();
        put_a(1'b0, 3'd0, 5'd16, 5'd0, 5'd0);
        put_b(1'b1, 3'd4, 5'd17, 5'd0, 5'd0);
        #1;
        chk("R8 A alu beside busy div", issue_a, 1);
        chk("R8 B divide while busy", issue_b, 0);
        next();
        idle();
        for (int k = 2; k <= 14; k++) begin
            put_a(1'b1, 3'd4, 5'd15, 5'd0, 5'd0);
            #1; chk("R8 divide while busy", issue_a, 0);
            next();
        end
        put_a(1'b1, 3'd4, 5'd15, 5'd0, 5'd0);
        #1; chk("R8 divide after free", issue_a, 1);
        next();
        drain();
    endtask

    task automatic t_fpcap();
        put_a(1'b1, 3'd4, 5'd10, 5'd0, 5'd0);
        #1; chk("R9 fp div", issue_a, 1);
        next();
        for (int k = 1; k <= 5; k++) begin
            put_a(1'b1, 3'd3, 5'(10 + k), 5'd0, 5'd0);
            #1; chk("R9 fill fp", issue_a, 1);
            next();
        end
        put_a(1'b0, 3'd0, 5'd20, 5'd0, 5'd0);
        put_b(1'b1, 3'd3, 5'd16, 5'd0, 5'd0);
        #1;
        chk("R9 int A with fp full", issue_a, 1);
        chk("R9 fp B with fp full", issue_b, 0);
        next();
        idle();
        put_a(1'b1, 3'd3, 5'd16, 5'd0, 5'd0);
        #1; chk("R9 fp slot freed", issue_a, 1);
        next();
        drain();
    endtask

    task automatic t_simul();
        put_a(1'b0, 3'd3, 5'd20, 5'd0, 5'd0);
        put_b(1'b1, 3'd3, 5'd21, 5'd0, 5'd0);
        #1; chk("R10 mul pair", {issue_a, issue_b}, 2'b11);
        next(); idle();
        repeat (3) next();
        put_a(1'b1, 3'd2, 5'd22, 5'd0, 5'd0);
        #1; chk("R10 fadd", issue_a, 1);
        next();
        put_a(1'b0, 3'd0, 5'd23, 5'd0, 5'd0);
        #1; chk("R10 alu", issue_a, 1);
        chk("R10 nothing early", wb, 0);
        next(); idle();
        chk("R10 four together", wb, 32'h00F0_0000);
        next();
        chk("R10 all cleared", wb, 0);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        next();
        t_reset();
        t_latency(1'b0, 3'd0, 5'd1, 1);
        t_latency(1'b0, 3'd1, 5'd2, 1);
        t_latency(1'b1, 3'd2, 5'd3, 2);
        t_latency(1'b0, 3'd3, 5'd4, 6);
        t_latency(1'b0, 3'd4, 5'd5, 15);
        t_latency(1'b0, 3'd7, 5'd6, 1);
        t_raw();
        t_waw();
        t_pair();
        t_div();
        t_fpcap();
        t_simul();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule